// File: doc/BRIEF.md
# Multicore Boot and Reset Configuration Block

This block is a register-mapped control unit for a cluster of four cores. Software reaches it over a simple 32-bit register bus that covers a 1 KiB window of byte offsets. Most locations are fixed-value status words kept so that boot firmware finds the values it expects. Three locations are real read/write storage: a general control word, a standby flag word and the boot entry address.

The one active function is core launch. Each core has its own reset slot. A nonzero write to a slot produces a one-clock power-on request for that core. The request carries the entry address held at the moment of the write and privilege level 3. Locations that exist but are not modelled, and offsets that decode to nothing, read as zero and raise sticky indication flags. Software clears those flags through a dedicated clear input.

The launch path is a two-state machine. In `LN_IDLE` no request is driven. The transition `go` (a nonzero slot write) moves it to `LN_FIRE`, where the request vector, address and level are driven for one cycle. From `LN_FIRE`, transition `again` (another nonzero slot write) stays in `LN_FIRE` with the new core. Transition `done` (anything else) returns to `LN_IDLE`. Reset forces `LN_IDLE`.

Top module: `core_boot_ctrl`

## Requirements
- R1: Synchronous active-high reset sets general control to 0x20, standby flag and entry address to 0, drops any power-on request and clears both indication flags.
- R2: A read request (`bus_req` high, `bus_we` low) produces `bus_rvalid` high with `bus_rdata` in the following cycle only. Whenever `bus_rvalid` is low, `bus_rdata` is 0, and write requests never raise `bus_rvalid`.
- R3: General control (offset 0x184), standby flag (0x1A0) and entry address (0x1A4) store and return all 32 bits written.
- R4: The reset slot of core n sits at offset 0x040 + 0x40*n (n = 0..3) and reads 0x3. A nonzero write to it makes `pwr_on_req` equal to 1<<n in the next cycle for exactly one cycle, with `pwr_on_addr` equal to the entry address at the time of the write and `pwr_on_el` equal to 3. Back-to-back nonzero writes give back-to-back pulses.
- R5: Writing zero to a core's reset slot raises no power-on request.
- R6: Core control (slot + 0x04) reads 0 and core status (slot + 0x08) reads 0x1. Writes to either are ignored.
- R7: The cluster reset word (0x000) and system reset word (0x140) read 0x1. The clock-gate word (0x144) reads 0x10F. Writes to these three are ignored.
- R8: The debug word (0x1E4) and the three counter words (0x280, 0x284, 0x288) read 0, ignore writes and set the sticky `unimp_flag`.
- R9: Any other offset, including offsets not on a 4-byte boundary, reads 0, ignores writes and sets the sticky `err_flag`.
- R10: `flag_clr` clears both flags in the next cycle. A flag-setting access in the same cycle takes priority and keeps its flag set.
- R11: Outside a power-on pulse, `pwr_on_addr` and `pwr_on_el` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | High for write, low for read |
| bus_addr | input | 10 | Byte offset in the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read response, one cycle after the request |
| flag_clr | input | 1 | Clears both indication flags |
| unimp_flag | output | 1 | Sticky: an unmodelled location was accessed |
| err_flag | output | 1 | Sticky: an undecoded offset was accessed |
| pwr_on_req | output | 4 | One-cycle power-on request, one bit per core |
| pwr_on_addr | output | 32 | Entry address for the request |
| pwr_on_el | output | 2 | Starting privilege level for the request |

## Verification
The assertions assume one access per cycle, with `bus_we` and `bus_wdata` meaningful only while `bus_req` is high. They also assume reset is held from time zero until the first clock edge. The stimulus drives all inputs right after a rising edge and keeps them steady for the whole cycle. It asserts reset from the start and never raises `bus_we` without `bus_req`, so the launch and flag properties see only well-formed accesses.

// File: rtl/core_boot_pkg.sv
`timescale 1ns/1ps
package core_boot_pkg;

    typedef enum logic [3:0] {
        RC_CLUSTER_RST,
        RC_CORE_RST,
        RC_CORE_CTRL,
        RC_CORE_STAT,
        RC_GATE,
        RC_GEN,
        RC_STBY,
        RC_ENTRY,
        RC_UNIMP,
        RC_BAD
    } reg_class_e;

    typedef enum logic {
        LN_IDLE,
        LN_FIRE
    } launch_state_e;

    // Slot geometry: core index = (offset - SLOT_BASE) >> 6
    localparam int unsigned SLOT_BASE   = 32'h040;
    localparam int unsigned SLOT_STRIDE = 32'h040;
    localparam int unsigned CTRL_OFS    = 32'h004;
    localparam int unsigned STAT_OFS    = 32'h008;

    localparam int unsigned A_CLUSTER = 32'h000;
    localparam int unsigned A_SYSRST  = 32'h140;
    localparam int unsigned A_GATE    = 32'h144;
    localparam int unsigned A_GEN     = 32'h184;
    localparam int unsigned A_STBY    = 32'h1A0;
    localparam int unsigned A_ENTRY   = 32'h1A4;
    localparam int unsigned A_DEBUG   = 32'h1E4;
    localparam int unsigned A_CNT_CTL = 32'h280;
    localparam int unsigned A_CNT_LO  = 32'h284;
    localparam int unsigned A_CNT_HI  = 32'h288;

    localparam logic [31:0] V_RELEASED  = 32'h1;
    localparam logic [31:0] V_CORE_RST  = 32'h3;
    localparam logic [31:0] V_CORE_STAT = 32'h1;
    localparam logic [31:0] V_GATE      = 32'h10F;
    localparam logic [31:0] V_GEN_INIT  = 32'h20;
    localparam logic [1:0]  V_BOOT_EL   = 2'd3;

endpackage

// File: rtl/cbc_decode.sv
`timescale 1ns/1ps
module cbc_decode
    import core_boot_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned CORES  = 4,
    localparam int unsigned IDX_W = (CORES > 1) ? $clog2(CORES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_class_e        cls,
    output logic [IDX_W-1:0]  core_idx
);

    always_comb begin
        cls      = RC_BAD;
        core_idx = '0;
        case (addr)
            ADDR_W'(A_CLUSTER), ADDR_W'(A_SYSRST): cls = RC_CLUSTER_RST;
            ADDR_W'(A_GATE):                      cls = RC_GATE;
            ADDR_W'(A_GEN):                       cls = RC_GEN;
            ADDR_W'(A_STBY):                      cls = RC_STBY;
            ADDR_W'(A_ENTRY):                     cls = RC_ENTRY;
            ADDR_W'(A_DEBUG), ADDR_W'(A_CNT_CTL),
            ADDR_W'(A_CNT_LO), ADDR_W'(A_CNT_HI): cls = RC_UNIMP;
            default:                              cls = RC_BAD;
        endcase
        for (int c = 0; c < CORES; c++) begin
            if (addr == ADDR_W'(SLOT_BASE + c * SLOT_STRIDE)) begin
                cls      = RC_CORE_RST;
                core_idx = IDX_W'(c);
            end
            if (addr == ADDR_W'(SLOT_BASE + c * SLOT_STRIDE + CTRL_OFS)) begin
                cls = RC_CORE_CTRL;
            end
            if (addr == ADDR_W'(SLOT_BASE + c * SLOT_STRIDE + STAT_OFS)) begin
                cls = RC_CORE_STAT;
            end
        end
    end

endmodule

// File: rtl/cbc_regs.sv
`timescale 1ns/1ps
module cbc_regs
    import core_boot_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  reg_class_e        cls,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] entry,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              unimp_flag,
    output logic              err_flag
);

    logic [DATA_W-1:0] gen_q, stby_q, entry_q, rd_mux;
    logic              wr, rd;

    assign wr    = req && we;
    assign rd    = req && !we;
    assign entry = entry_q;

    always_comb begin
        unique case (cls)
            RC_CLUSTER_RST: rd_mux = DATA_W'(V_RELEASED);
            RC_CORE_RST:    rd_mux = DATA_W'(V_CORE_RST);
            RC_CORE_STAT:   rd_mux = DATA_W'(V_CORE_STAT);
            RC_GATE:        rd_mux = DATA_W'(V_GATE);
            RC_GEN:         rd_mux = gen_q;
            RC_STBY:        rd_mux = stby_q;
            RC_ENTRY:       rd_mux = entry_q;
            default:        rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q   <= DATA_W'(V_GEN_INIT);
            stby_q  <= '0;
            entry_q <= '0;
        end else if (wr) begin
            if (cls == RC_GEN)   gen_q   <= wdata;
            if (cls == RC_STBY)  stby_q  <= wdata;
            if (cls == RC_ENTRY) entry_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd;
            rdata  <= rd ? rd_mux : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unimp_flag <= 1'b0;
            err_flag   <= 1'b0;
        end else begin
            if (req && cls == RC_UNIMP) unimp_flag <= 1'b1;
            else if (flag_clr)          unimp_flag <= 1'b0;
            if (req && cls == RC_BAD)   err_flag <= 1'b1;
            else if (flag_clr)          err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cbc_launch.sv
`timescale 1ns/1ps
module cbc_launch
    import core_boot_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CORES  = 4,
    parameter int unsigned EL_W   = 2,
    localparam int unsigned IDX_W = (CORES > 1) ? $clog2(CORES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic [DATA_W-1:0] entry,
    output logic [CORES-1:0]  pwr_on_req,
    output logic [DATA_W-1:0] pwr_on_addr,
    output logic [EL_W-1:0]   pwr_on_el
);

    launch_state_e     state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (hit) state_d = LN_FIRE;   // go
            LN_FIRE: state_d = hit ? LN_FIRE       // again
                                   : LN_IDLE;      // done
            default: state_d = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LN_IDLE;
            idx_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (hit) begin
                idx_q  <= hit_idx;
                addr_q <= entry;
            end
        end
    end

    always_comb begin
        pwr_on_req  = '0;
        pwr_on_addr = '0;
        pwr_on_el   = '0;
        unique case (state_q)
            LN_IDLE: ;
            LN_FIRE: begin
                pwr_on_req[idx_q] = 1'b1;
                pwr_on_addr       = addr_q;
                pwr_on_el         = EL_W'(V_BOOT_EL);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/core_boot_ctrl.sv
`timescale 1ns/1ps
module core_boot_ctrl
    import core_boot_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CORES  = 4,
    parameter int unsigned EL_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              flag_clr,
    output logic              unimp_flag,
    output logic              err_flag,
    output logic [CORES-1:0]  pwr_on_req,
    output logic [DATA_W-1:0] pwr_on_addr,
    output logic [EL_W-1:0]   pwr_on_el
);

    localparam int unsigned IDX_W = (CORES > 1) ? $clog2(CORES) : 1;

    reg_class_e        cls;
    logic [IDX_W-1:0]  core_idx;
    logic [DATA_W-1:0] entry;
    logic              launch_hit;

    cbc_decode #(.ADDR_W(ADDR_W), .CORES(CORES)) u_decode (
        .addr     (bus_addr),
        .cls      (cls),
        .core_idx (core_idx)
    );

    cbc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req        (bus_req),
        .we         (bus_we),
        .wdata      (bus_wdata),
        .cls        (cls),
        .flag_clr   (flag_clr),
        .entry      (entry),
        .rdata      (bus_rdata),
        .rvalid     (bus_rvalid),
        .unimp_flag (unimp_flag),
        .err_flag   (err_flag)
    );

    assign launch_hit = bus_req && bus_we && (cls == RC_CORE_RST) && (bus_wdata != '0);

    cbc_launch #(.DATA_W(DATA_W), .CORES(CORES), .EL_W(EL_W)) u_launch (
        .clk         (clk),
        .rst         (rst),
        .hit         (launch_hit),
        .hit_idx     (core_idx),
        .entry       (entry),
        .pwr_on_req  (pwr_on_req),
        .pwr_on_addr (pwr_on_addr),
        .pwr_on_el   (pwr_on_el)
    );

endmodule

// File: rtl/cbc_checker.sv
`timescale 1ns/1ps
module cbc_checker #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CORES  = 4,
    parameter int unsigned EL_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              flag_clr,
    input logic              unimp_flag,
    input logic              err_flag,
    input logic [CORES-1:0]  pwr_on_req,
    input logic [DATA_W-1:0] pwr_on_addr,
    input logic [EL_W-1:0]   pwr_on_el
);

    p_req_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pwr_on_req));

    p_req_cause_r4: assert property (@(posedge clk) disable iff (rst)
        (pwr_on_req != '0) |-> $past(bus_req && bus_we && (bus_wdata != '0)));

    p_req_level_r4: assert property (@(posedge clk) disable iff (rst)
        (pwr_on_req != '0) |-> (pwr_on_el == EL_W'(3)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr_on_req == '0) |-> (pwr_on_addr == '0 && pwr_on_el == '0));

    p_rvalid_cause_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_req && !bus_we));

    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> (bus_rdata == '0));

    p_write_no_resp_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |=> !bus_rvalid);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !bus_req) |=> (!unimp_flag && !err_flag));

endmodule

bind core_boot_ctrl cbc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORES(CORES), .EL_W(EL_W)
) u_cbc_checker (
    .clk         (clk),
    .rst         (rst),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .flag_clr    (flag_clr),
    .unimp_flag  (unimp_flag),
    .err_flag    (err_flag),
    .pwr_on_req  (pwr_on_req),
    .pwr_on_addr (pwr_on_addr),
    .pwr_on_el   (pwr_on_el)
);

// File: tb/core_boot_ctrl_bench.sv
`timescale 1ns/1ps
module core_boot_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0, flag_clr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pwr_on_addr;
    logic        bus_rvalid, unimp_flag, err_flag;
    logic [3:0]  pwr_on_req;
    logic [1:0]  pwr_on_el;

    int n_chk = 0, n_bad = 0;

    // Reference state
    logic [31:0] m_gen = 32'h20, m_stby = 0, m_entry = 0;
    logic        m_unimp = 0, m_err = 0;

    always #4 clk = ~clk;   // 125 MHz

    core_boot_ctrl u_core_boot_ctrl (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .flag_clr(flag_clr), .unimp_flag(unimp_flag),
        .err_flag(err_flag), .pwr_on_req(pwr_on_req), .pwr_on_addr(pwr_on_addr),
        .pwr_on_el(pwr_on_el)
    );

    function automatic int slot_of(int a);
        if (a >= 'h40 && a < 'h140 && (a % 'h40) == 0) return (a - 'h40) / 'h40;
        return -1;
    endfunction

    function automatic bit is_unimp(int a);
        return a == 'h1E4 || a == 'h280 || a == 'h284 || a == 'h288;
    endfunction

    // -1: not a core sub-register, else byte offset inside the core's slot
    function automatic int core_sub(int a);
        if (a >= 'h40 && a < 'h140 && ((a % 'h40) == 0 || (a % 'h40) == 4 || (a % 'h40) == 8))
            return a % 'h40;
        return -1;
    endfunction

    function automatic bit is_known(int a);
        return a == 0 || a == 'h140 || a == 'h144 || a == 'h184 || a == 'h1A0 ||
               a == 'h1A4 || is_unimp(a) || core_sub(a) >= 0;
    endfunction

    function automatic logic [31:0] mread(int a);
        if (a == 0 || a == 'h140) return 32'h1;
        if (a == 'h144) return 32'h10F;
        if (a == 'h184) return m_gen;
        if (a == 'h1A0) return m_stby;
        if (a == 'h1A4) return m_entry;
        if (core_sub(a) == 0) return 32'h3;
        if (core_sub(a) == 8) return 32'h1;
        return 32'h0;
    endfunction

    function automatic string rtag(int a);
        if (a == 'h184 || a == 'h1A0 || a == 'h1A4) return "R3";
        if (core_sub(a) == 0) return "R4";
        if (core_sub(a) > 0) return "R6";
        if (a == 0 || a == 'h140 || a == 'h144) return "R7";
        if (is_unimp(a)) return "R8";
        return "R9";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic w, input int a, input logic [31:0] d, input logic c);
        logic        e_rv;
        logic [31:0] e_rd, e_pa;
        logic [3:0]  e_pr;
        logic [1:0]  e_el;
        string       t_rd, t_pl, t_fl;
        bus_req = r; bus_we = w; bus_addr = a[9:0]; bus_wdata = d; flag_clr = c;
        @(posedge clk); #1;
        if (rst) begin
            m_gen = 32'h20; m_stby = 0; m_entry = 0; m_unimp = 0; m_err = 0;
            e_rv = 0; e_rd = 0; e_pr = 0; e_pa = 0; e_el = 0;
            t_rd = "R1"; t_pl = "R1"; t_fl = "R1";
        end else begin
            e_rv = r && !w;
            e_rd = e_rv ? mread(a) : 32'h0;
            t_rd = e_rv ? rtag(a) : "R2";
            e_pr = 0; e_pa = 0; e_el = 0; t_pl = "R11";
            if (r && w && slot_of(a) >= 0) begin
                if (d != 0) begin
                    e_pr = 4'b1 << slot_of(a); e_pa = m_entry; e_el = 2'd3; t_pl = "R4";
                end else t_pl = "R5";
            end
            t_fl = c ? "R10" : (r && is_unimp(a)) ? "R8" : "R9";
            if (r && is_unimp(a)) m_unimp = 1; else if (c) m_unimp = 0;
            if (r && !is_known(a)) m_err = 1;  else if (c) m_err = 0;
            if (r && w) begin
                if (a == 'h184) m_gen = d;
                if (a == 'h1A0) m_stby = d;
                if (a == 'h1A4) m_entry = d;
            end
        end
        chk(bus_rvalid === e_rv && bus_rdata === e_rd, t_rd,
            {31'b0, bus_rvalid, bus_rdata}, {31'b0, e_rv, e_rd});
        chk(pwr_on_req === e_pr && pwr_on_addr === e_pa && pwr_on_el === e_el, t_pl,
            {26'b0, pwr_on_req, pwr_on_el, pwr_on_addr}, {26'b0, e_pr, e_el, e_pa});
        chk(unimp_flag === m_unimp && err_flag === m_err, t_fl,
            {62'b0, unimp_flag, err_flag}, {62'b0, m_unimp, m_err});
    endtask

    task automatic rd(input int a);                  step(1, 0, a, 0, 0); endtask
    task automatic wr(input int a, input logic [31:0] d); step(1, 1, a, d, 0); endtask
    task automatic idle();                           step(0, 0, 0, 0, 0); endtask

    initial begin
        // R1: reset state
        rst = 1;
        repeat (3) step(1, 1, 'h1A4, 32'hFFFF_FFFF, 0);
        rst = 0;
        rd('h184); rd('h1A0); rd('h1A4);             // R1 reset values
        // R7, R4, R6: fixed words
        rd('h000); rd('h140); rd('h144);
        for (int c = 0; c < 4; c++) begin
            rd('h40 + c * 'h40); rd('h44 + c * 'h40); rd('h48 + c * 'h40);
        end
        // R3: storage
        wr('h184, 32'hDEAD_BEEF); wr('h1A0, 32'h0000_0001); wr('h1A4, 32'h8000_0000);
        rd('h184); rd('h1A0); rd('h1A4);
        wr('h184, 32'h0); rd('h184); wr('h184, 32'hFFFF_FFFF); rd('h184);
        // R6, R7: writes ignored
        wr('h000, 32'h0); wr('h140, 32'h0); wr('h144, 32'h0);
        wr('h44, 32'hFFFF_FFFF); wr('h88, 32'h0);
        rd('h000); rd('h140); rd('h144); rd('h44); rd('h88); rd('h184);
        // R4: launch each core with distinct entry addresses
        for (int c = 0; c < 4; c++) begin
            wr('h1A4, 32'h4000_0000 + c * 32'h100);
            wr('h40 + c * 'h40, 32'h1 << c); idle(); idle();
        end
        // R4: back-to-back launches, R5: zero write
        wr('h1A4, 32'h1234_5678);
        wr('h80, 32'h3); wr('h100, 32'h1); wr('hC0, 32'h0); idle();
        wr('h40, 32'h0); idle();                       // R5
        rd('h40);
        // R8: unmodelled words
        wr('h1E4, 32'hFFFF_FFFF); rd('h1E4); rd('h280); rd('h284); rd('h288);
        rd('h184);
        // R9: undecoded and misaligned offsets
        wr('h3FC, 32'h5A5A_5A5A); rd('h3FC); rd('h042); rd('h1A6); rd('h04C);
        wr('h041, 32'h1); idle();                       // R9: no launch
        rd('h1A4);
        // R10: clear, then clear collides with a new event
        step(0, 0, 0, 0, 1); idle();
        step(1, 0, 'h284, 0, 1); idle();
        step(1, 0, 'h300, 0, 1); step(0, 0, 0, 0, 1);
        // R1: reset mid-run restores defaults
        wr('h184, 32'h77); wr('h1E4, 0);
        rst = 1; step(1, 1, 'h40, 32'h1, 0); rst = 0;
        rd('h184); rd('h1A0); rd('h1A4); idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule